// File: doc/BRIEF.md
# Pivot Partition Unit

This block performs one partition step of a quicksort-style algorithm on a chunk of `LANES` unsigned words, all arriving in the same cycle. Each chunk comes with its own pivot. Every lane is compared with that pivot. The lanes that are not greater than the pivot are then moved to the front of the vector by a network of compare-exchange layers keyed on the one-bit comparison result. The block returns the reordered chunk and a split index. Lanes below the split index form the low side and all other lanes form the high side.

The unit is fully pipelined. A chunk can be accepted on every clock, and each chunk leaves after a fixed number of cycles. The surrounding logic joins the low and high sides of successive chunks. It also picks the pivots.

The swap network is built from adjacent exchanges. An exchange happens only when a high element sits directly before a low element. As a result, both sides keep the order the elements had at the input. The parameter `NET_MODE` selects the pipelining of the network. In one variant every layer has its own register. In the other variant all layers form one combinational stage.

Top module: `pivot_split_unit`

## Requirements
- R1: A lane is classed low exactly when its element, read as an unsigned `WIDTH`-bit number, is less than or equal to the pivot of its chunk. An element equal to the pivot is low. With `WIDTH`=8, 0x80 is above a pivot of 0x7F.
- R2: `out_split` equals the number of low lanes in the chunk. Its value lies between 0 and `LANES` inclusive.
- R3: Lane i occupies bits `[i*WIDTH +: WIDTH]`, and lane 0 is the front. Output lanes 0 to `out_split`-1 hold the low elements, in their input lane order.
- R4: Output lanes `out_split` to `LANES`-1 hold the high elements, in their input lane order.
- R5: A chunk accepted with `in_valid` high appears with `out_valid` high exactly `LANES`+2 clock edges later when every network layer is registered, and exactly 3 edges later in the single-stage mode.
- R6: Each chunk is partitioned against the pivot presented in its own cycle. Back-to-back chunks with different pivots do not affect each other.
- R7: While `rst_n` is low, `out_valid` is low. Chunks in flight when reset is applied are dropped.
- R8: A new chunk is accepted on every cycle with `in_valid` high. A cycle with `in_valid` low yields a cycle with `out_valid` low at the output, whatever the data and pivot inputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A chunk is presented this cycle |
| in_data | input | LANES*WIDTH | Chunk elements, lane i at bits [i*WIDTH +: WIDTH] |
| in_pivot | input | WIDTH | Pivot for this chunk |
| out_valid | output | 1 | A partitioned chunk is presented |
| out_data | output | LANES*WIDTH | Reordered chunk, low side first |
| out_split | output | $clog2(LANES+1) | Number of low lanes |

## Verification
The stimulus drives all-low chunks (pivot at the maximum, split = `LANES`) and all-high chunks (pivot 0 and no zero elements, split = 0). A counter that saturates or wraps would report the wrong split in these cases. Chunks built from the pivot and its neighbours probe the equality edge, and chunks with the most significant bit set probe signedness. A strict or signed compare would move lanes to the wrong side.

The pivot changes on every cycle of a back-to-back burst. This catches a pivot register that falls out of step with its data. Random bubbles and a reset while chunks are in flight check that the valid pipeline matches the data pipeline. Exact lane-by-lane comparison also exposes any network that reorders elements within a side.

// File: rtl/pvp_pkg.sv
package pvp_pkg;

   // Pipelining variant of the compaction network
   typedef enum logic {
      PVP_NET_EACH_LAYER = 1'b0,   // one register after every exchange layer
      PVP_NET_ONE_STAGE  = 1'b1    // all layers combinational, one register
   } pvp_net_mode_e;

   // Registers ahead of the network: input capture and compare result
   localparam int PVP_FRONT_LAT = 2;

   function automatic int pvp_net_latency(int lanes, pvp_net_mode_e mode);
      return (mode == PVP_NET_EACH_LAYER) ? lanes : 1;
   endfunction

endpackage

// File: rtl/pvp_flag_stage.sv
module pvp_flag_stage #(
   parameter int LANES = 8,
   parameter int WIDTH = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [LANES*WIDTH-1:0] in_data,
   input  logic [WIDTH-1:0]       in_pivot,
   output logic                   f_valid,
   output logic [LANES*WIDTH-1:0] f_data,
   output logic [LANES-1:0]       f_flag
);

   logic                   cap_valid;
   logic [LANES*WIDTH-1:0] cap_data;
   logic [WIDTH-1:0]       cap_pivot;
   logic [LANES-1:0]       cmp_flag;

   // Stage 1: capture chunk together with its own pivot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_valid <= 1'b0;
         f_valid   <= 1'b0;
      end else begin
         cap_valid <= in_valid;
         f_valid   <= cap_valid;
      end
   end

   always_ff @(posedge clk) begin
      cap_data  <= in_data;
      cap_pivot <= in_pivot;
      f_data    <= cap_data;
      f_flag    <= cmp_flag;
   end

   // Stage 2: unsigned per-lane compare against broadcast pivot
   for (genvar i = 0; i < LANES; i++) begin : g_cmp
      assign cmp_flag[i] = (cap_data[i*WIDTH +: WIDTH] <= cap_pivot);
   end

endmodule

// File: rtl/pvp_swap_layer.sv
module pvp_swap_layer #(
   parameter int LANES = 8,
   parameter int WIDTH = 8,
   parameter int PHASE = 0
) (
   input  logic [LANES*WIDTH-1:0] in_data,
   input  logic [LANES-1:0]       in_flag,
   output logic [LANES*WIDTH-1:0] out_data,
   output logic [LANES-1:0]       out_flag
);

   // Pairs (j, j+1) with j%2 == PHASE exchange only when a high lane
   // precedes a low lane; equal keys never move, so order is preserved.
   for (genvar j = 0; j < LANES; j++) begin : g_lane
      localparam bit IS_LEFT  = ((j % 2) == PHASE) && (j + 1 < LANES);
      localparam bit IS_RIGHT = ((j % 2) != PHASE) && (j >= 1);
      if (IS_LEFT) begin : g_left
         logic xchg;
         assign xchg = !in_flag[j] && in_flag[j+1];
         assign out_data[j*WIDTH +: WIDTH] = xchg ? in_data[(j+1)*WIDTH +: WIDTH]
                                                  : in_data[j*WIDTH +: WIDTH];
         assign out_flag[j] = xchg ? in_flag[j+1] : in_flag[j];
      end else if (IS_RIGHT) begin : g_right
         logic xchg;
         assign xchg = !in_flag[j-1] && in_flag[j];
         assign out_data[j*WIDTH +: WIDTH] = xchg ? in_data[(j-1)*WIDTH +: WIDTH]
                                                  : in_data[j*WIDTH +: WIDTH];
         assign out_flag[j] = xchg ? in_flag[j-1] : in_flag[j];
      end else begin : g_pass
         assign out_data[j*WIDTH +: WIDTH] = in_data[j*WIDTH +: WIDTH];
         assign out_flag[j] = in_flag[j];
      end
   end

endmodule

// File: rtl/pvp_compact_net.sv
module pvp_compact_net
   import pvp_pkg::*;
#(
   parameter int            LANES    = 8,
   parameter int            WIDTH    = 8,
   parameter pvp_net_mode_e NET_MODE = PVP_NET_EACH_LAYER
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [LANES*WIDTH-1:0] in_data,
   input  logic [LANES-1:0]       in_flag,
   output logic                   out_valid,
   output logic [LANES*WIDTH-1:0] out_data,
   output logic [LANES-1:0]       out_flag
);

   // LANES alternating layers fully sort a one-bit key
   if (NET_MODE == PVP_NET_EACH_LAYER) begin : g_each
      logic [LANES*WIDTH-1:0] w_data [LANES];
      logic [LANES-1:0]       w_flag [LANES];
      logic [LANES*WIDTH-1:0] q_data [LANES];
      logic [LANES-1:0]       q_flag [LANES];
      logic [LANES-1:0]       q_valid;

      for (genvar l = 0; l < LANES; l++) begin : g_layer
         if (l == 0) begin : g_first
            pvp_swap_layer #(.LANES(LANES), .WIDTH(WIDTH), .PHASE(l % 2)) u_layer (
               .in_data (in_data),
               .in_flag (in_flag),
               .out_data(w_data[l]),
               .out_flag(w_flag[l])
            );
         end else begin : g_next
            pvp_swap_layer #(.LANES(LANES), .WIDTH(WIDTH), .PHASE(l % 2)) u_layer (
               .in_data (q_data[l-1]),
               .in_flag (q_flag[l-1]),
               .out_data(w_data[l]),
               .out_flag(w_flag[l])
            );
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_valid <= '0;
         else        q_valid <= {q_valid[LANES-2:0], in_valid};
      end

      always_ff @(posedge clk) begin
         for (int l = 0; l < LANES; l++) begin
            q_data[l] <= w_data[l];
            q_flag[l] <= w_flag[l];
         end
      end

      assign out_valid = q_valid[LANES-1];
      assign out_data  = q_data[LANES-1];
      assign out_flag  = q_flag[LANES-1];
   end else begin : g_one
      logic [LANES*WIDTH-1:0] w_data [LANES];
      logic [LANES-1:0]       w_flag [LANES];
      logic                   r_valid;
      logic [LANES*WIDTH-1:0] r_data;
      logic [LANES-1:0]       r_flag;

      for (genvar l = 0; l < LANES; l++) begin : g_layer
         if (l == 0) begin : g_first
            pvp_swap_layer #(.LANES(LANES), .WIDTH(WIDTH), .PHASE(l % 2)) u_layer (
               .in_data (in_data),
               .in_flag (in_flag),
               .out_data(w_data[l]),
               .out_flag(w_flag[l])
            );
         end else begin : g_next
            pvp_swap_layer #(.LANES(LANES), .WIDTH(WIDTH), .PHASE(l % 2)) u_layer (
               .in_data (w_data[l-1]),
               .in_flag (w_flag[l-1]),
               .out_data(w_data[l]),
               .out_flag(w_flag[l])
            );
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r_valid <= 1'b0;
         else        r_valid <= in_valid;
      end

      always_ff @(posedge clk) begin
         r_data <= w_data[LANES-1];
         r_flag <= w_flag[LANES-1];
      end

      assign out_valid = r_valid;
      assign out_data  = r_data;
      assign out_flag  = r_flag;
   end

endmodule

// File: rtl/pivot_split_unit.sv
module pivot_split_unit
   import pvp_pkg::*;
#(
   parameter int            LANES    = 8,
   parameter int            WIDTH    = 8,
   parameter pvp_net_mode_e NET_MODE = PVP_NET_EACH_LAYER,
   localparam int           CNT_W    = $clog2(LANES + 1),
   localparam int           LATENCY  = PVP_FRONT_LAT + pvp_net_latency(LANES, NET_MODE)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [LANES*WIDTH-1:0] in_data,
   input  logic [WIDTH-1:0]       in_pivot,
   output logic                   out_valid,
   output logic [LANES*WIDTH-1:0] out_data,
   output logic [CNT_W-1:0]       out_split
);

   if (LANES < 2) begin : g_bad_lanes
      $error("pivot_split_unit: LANES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("pivot_split_unit: WIDTH must be at least 1");
   end

   logic                   f_valid;
   logic [LANES*WIDTH-1:0] f_data;
   logic [LANES-1:0]       f_flag;
   logic [LANES-1:0]       sorted_flag;
   logic [CNT_W-1:0]       low_cnt;

   pvp_flag_stage #(.LANES(LANES), .WIDTH(WIDTH)) u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_valid(in_valid),
      .in_data (in_data),
      .in_pivot(in_pivot),
      .f_valid (f_valid),
      .f_data  (f_data),
      .f_flag  (f_flag)
   );

   pvp_compact_net #(.LANES(LANES), .WIDTH(WIDTH), .NET_MODE(NET_MODE)) u_net (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (f_valid),
      .in_data  (f_data),
      .in_flag  (f_flag),
      .out_valid(out_valid),
      .out_data (out_data),
      .out_flag (sorted_flag)
   );

   // Split index: number of low keys that travelled with the chunk
   always_comb begin
      low_cnt = '0;
      for (int i = 0; i < LANES; i++) begin
         low_cnt = low_cnt + CNT_W'(sorted_flag[i]);
      end
   end

   assign out_split = low_cnt;

endmodule

// File: rtl/pvp_checker.sv
module pvp_checker #(
   parameter int LANES = 8,
   parameter int WIDTH = 8,
   parameter int CNT_W = 4,
   parameter int LAT   = 10
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_valid,
   input logic [WIDTH-1:0]       in_pivot,
   input logic                   out_valid,
   input logic [LANES*WIDTH-1:0] out_data,
   input logic [CNT_W-1:0]       out_split
);

   logic [LAT-1:0]   v_shadow;
   logic [WIDTH-1:0] p_shadow [LAT];
   logic             low_ok;
   logic             high_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_shadow <= '0;
         for (int i = 0; i < LAT; i++) p_shadow[i] <= '0;
      end else begin
         v_shadow    <= {v_shadow[LAT-2:0], in_valid};
         p_shadow[0] <= in_pivot;
         for (int i = 1; i < LAT; i++) p_shadow[i] <= p_shadow[i-1];
      end
   end

   always_comb begin
      low_ok  = 1'b1;
      high_ok = 1'b1;
      for (int j = 0; j < LANES; j++) begin
         if (j < int'(out_split)) low_ok  = low_ok  && (out_data[j*WIDTH +: WIDTH] <= p_shadow[LAT-1]);
         else                     high_ok = high_ok && (out_data[j*WIDTH +: WIDTH] >  p_shadow[LAT-1]);
      end
   end

   a_r5_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == v_shadow[LAT-1]);

   a_r2_split_range: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(out_split) <= LANES));

   a_r3_low_side: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> low_ok);

   a_r4_high_side: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> high_ok);

   a_r7_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !out_valid);

endmodule

bind pivot_split_unit pvp_checker #(
   .LANES(LANES), .WIDTH(WIDTH), .CNT_W(CNT_W), .LAT(LATENCY)
) u_pvp_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_pivot (in_pivot),
   .out_valid(out_valid),
   .out_data (out_data),
   .out_split(out_split)
);

// File: tb/test_pivot_split_unit.sv
module test_pivot_split_unit;

   localparam int  LANES      = 8;
   localparam int  WIDTH      = 8;
   localparam int  CNT_W      = $clog2(LANES + 1);
   localparam int  LAT        = LANES + 2;   // R5, every layer registered
   localparam time CLK_PERIOD = 10;

   typedef struct {
      bit                     v;
      logic [LANES*WIDTH-1:0] d;
      int                     s;
   } exp_t;

   logic                   clk = 1'b0;
   logic                   rst_n;
   logic                   in_valid;
   logic [LANES*WIDTH-1:0] in_data;
   logic [WIDTH-1:0]       in_pivot;
   logic                   out_valid;
   logic [LANES*WIDTH-1:0] out_data;
   logic [CNT_W-1:0]       out_split;

   exp_t pipe_q[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pivot_split_unit #(.LANES(LANES), .WIDTH(WIDTH)) i_pivot_split_unit (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_data  (in_data),
      .in_pivot (in_pivot),
      .out_valid(out_valid),
      .out_data (out_data),
      .out_split(out_split)
   );

   // Behavioural reference: stable split into two queues
   function automatic exp_t model_of(bit v, logic [LANES*WIDTH-1:0] d, logic [WIDTH-1:0] p);
      exp_t e;
      logic [WIDTH-1:0] lo[$];
      logic [WIDTH-1:0] hi[$];
      int k;
      e.v = v;
      e.d = '0;
      for (int i = 0; i < LANES; i++) begin
         logic [WIDTH-1:0] x;
         x = d[i*WIDTH +: WIDTH];
         if (x <= p) lo.push_back(x);
         else        hi.push_back(x);
      end
      e.s = lo.size();
      k = 0;
      foreach (lo[i]) begin e.d[k*WIDTH +: WIDTH] = lo[i]; k++; end
      foreach (hi[i]) begin e.d[k*WIDTH +: WIDTH] = hi[i]; k++; end
      return e;
   endfunction

   task automatic check_now(string ph);
      exp_t e;
      if (pipe_q.size() >= LAT) e = pipe_q.pop_front();
      else begin e.v = 1'b0; e.d = '0; e.s = 0; end
      n_cmp++;
      if (out_valid !== e.v) begin
         n_bad++;
         $display("FAIL R5/R8 [%s] out_valid actual %b expected %b", ph, out_valid, e.v);
      end else if (e.v) begin
         n_cmp++;
         if (out_split !== CNT_W'(e.s)) begin
            n_bad++;
            $display("FAIL R2 [%s] out_split actual %0d expected %0d", ph, out_split, e.s);
         end
         for (int j = 0; j < LANES; j++) begin
            n_cmp++;
            if (out_data[j*WIDTH +: WIDTH] !== e.d[j*WIDTH +: WIDTH]) begin
               n_bad++;
               $display("FAIL %s [%s] lane %0d actual %h expected %h",
                        (j < e.s) ? "R3" : "R4", ph, j,
                        out_data[j*WIDTH +: WIDTH], e.d[j*WIDTH +: WIDTH]);
            end
         end
      end
   endtask

   task automatic step(bit v, logic [LANES*WIDTH-1:0] d, logic [WIDTH-1:0] p, string ph);
      @(negedge clk);
      check_now(ph);
      in_valid = v;
      in_data  = d;
      in_pivot = p;
      pipe_q.push_back(model_of(v, d, p));
   endtask

   task automatic release_reset();
      exp_t b;
      b.v = 1'b0; b.d = '0; b.s = 0;
      rst_n = 1'b1;
      pipe_q.push_back(b);
   endtask

   function automatic logic [LANES*WIDTH-1:0] rand_chunk();
      logic [LANES*WIDTH-1:0] d;
      for (int i = 0; i < LANES; i++) d[i*WIDTH +: WIDTH] = WIDTH'($urandom);
      return d;
   endfunction

   initial begin
      logic [LANES*WIDTH-1:0] d;
      rst_n    = 1'b0;
      in_valid = 1'b0;
      in_data  = '0;
      in_pivot = '0;
      repeat (3) @(negedge clk);
      n_cmp++;   // R7 reset state
      if (out_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R7 out_valid during reset actual %b expected 0", out_valid);
      end
      release_reset();

      // R5: isolated chunks, latency observed through valid
      for (int n = 0; n < 3; n++) begin
         step(1'b1, rand_chunk(), 8'h80, "R5");
         repeat (LAT + 1) step(1'b0, rand_chunk(), 8'h00, "R5");
      end

      // R2: all low (pivot max) and all high (pivot 0, no zeros)
      step(1'b1, rand_chunk(), 8'hFF, "R2");
      for (int i = 0; i < LANES; i++) d[i*WIDTH +: WIDTH] = WIDTH'(1 + ($urandom % 255));
      step(1'b1, d, 8'h00, "R2");
      step(1'b1, '0, 8'h00, "R2");

      // R1: equality edge and unsigned reading of the top bit
      for (int n = 0; n < 12; n++) begin
         logic [WIDTH-1:0] p;
         p = (n < 6) ? 8'h7F : WIDTH'($urandom);
         for (int i = 0; i < LANES; i++) begin
            int s;
            s = $urandom % 3;
            d[i*WIDTH +: WIDTH] = (s == 0) ? p - 8'd1 : (s == 1) ? p : p + 8'd1;
         end
         step(1'b1, d, p, "R1");
      end

      // R3/R4: alternating low/high lanes
      for (int i = 0; i < LANES; i++) d[i*WIDTH +: WIDTH] = (i % 2) ? WIDTH'(8'hC0 + i) : WIDTH'(8'h10 + i);
      step(1'b1, d, 8'h40, "R3");
      for (int i = 0; i < LANES; i++) d[i*WIDTH +: WIDTH] = (i % 2) ? WIDTH'(8'h10 + i) : WIDTH'(8'hC0 + i);
      step(1'b1, d, 8'h40, "R4");

      // R6: back-to-back chunks, pivot changes every cycle
      for (int n = 0; n < 40; n++) step(1'b1, rand_chunk(), WIDTH'($urandom), "R6");

      // R8: random bubbles with garbage on the inputs
      for (int n = 0; n < 200; n++) step(($urandom % 3) != 0, rand_chunk(), WIDTH'($urandom), "R8");

      // R7: reset with chunks in flight
      for (int n = 0; n < 5; n++) step(1'b1, rand_chunk(), WIDTH'($urandom), "R7");
      @(negedge clk);
      check_now("R7");
      rst_n    = 1'b0;
      in_valid = 1'b0;
      pipe_q.delete();
      @(negedge clk);
      n_cmp++;
      if (out_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R7 out_valid in reset actual %b expected 0", out_valid);
      end
      release_reset();
      for (int n = 0; n < 30; n++) step(1'b1, rand_chunk(), WIDTH'($urandom), "R7");

      repeat (LAT + 2) step(1'b0, '0, '0, "drain");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R5 watchdog: run active actual 1 expected 0");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule